// File: doc/BRIEF.md
# Per-Class Register Rename Table

This block holds the speculative architectural-to-physical register map for one class of registers in an out-of-order core. Indices are relative to the class, so register 2 of the class is entry 2. Next to the map it keeps its own circular queue of free physical tags. A rename request takes a destination index, draws the oldest free tag, writes it into the map, and reports both the new tag and the tag it displaced. The displaced tag can then be retired later, or written back to undo the rename.

Source operands are translated through a parameterised number of combinational lookup ports. During a squash, a set-entry port writes a chosen tag into a chosen entry. A release port returns tags to the free queue, and a count output reports how many tags are ready for allocation.

One index of the class may be declared the hardwired zero register. Renaming that index leaves everything unchanged. Setting that index to a value at or above the register count removes the feature.

Top module: `rename_table`

## Requirements
- R1: After reset, entry i maps to tag i, the free count equals PHYS_REGS-ARCH_REGS, and the first allocations hand out tags ARCH_REGS, ARCH_REGS+1, … in ascending order.
- R2: An accepted rename of index a drives `ren_new` with the oldest free tag and `ren_prev` with the current map entry a, in the same cycle. From the next cycle, lookups of a return the new tag.
- R3: A rename of index ZERO_IDX (when ZERO_IDX < ARCH_REGS) returns the current mapping on both `ren_new` and `ren_prev`. It never stalls, does not consume a free tag and leaves the map unchanged.
- R4: With ZERO_IDX >= ARCH_REGS no index is protected, and a rename of index 0 allocates normally.
- R5: Every lookup port returns the current mapping combinationally. A lookup of an index renamed in the same cycle returns the mapping from before the rename.
- R6: The set-entry port writes its tag into its entry on the next edge, for any index including the zero register. When it targets the same entry as an accepted rename in the same cycle, the set-entry tag is the one kept.
- R7: `free_cnt` drops by one for each accepted rename and rises by one for each release. A release together with an accepted rename leaves it unchanged. Released tags are handed out in the order they were released, after the tags already queued.
- R8: A non-zero-register rename while `free_cnt` is 0 raises `ren_stall`. The map and the count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Destination index to rename |
| ren_new | output | PW | Tag now assigned to the destination |
| ren_prev | output | PW | Tag the destination held before |
| ren_stall | output | 1 | Request refused, no free tag |
| lk_arch | input | NUM_SRC*AW | Packed source indices, port k at bits [k*AW +: AW] |
| lk_tag | output | NUM_SRC*PW | Packed source tags, same order |
| fix_valid | input | 1 | Force one map entry |
| fix_arch | input | AW | Entry to force |
| fix_tag | input | PW | Tag to write |
| rel_valid | input | 1 | Return a tag to the free queue |
| rel_tag | input | PW | Tag being returned |
| free_cnt | output | CW | Number of free tags |

## Verification
A corrupted map entry shows up in the same cycle as a wrong `ren_prev` or lookup tag, whenever that index is next read. A slip in the free-queue pointers appears as a wrong `ren_new` on the next accepted rename. A miscounted occupancy appears at once on `free_cnt`, and as a stall at the wrong moment. The bench keeps a full reference map and free-queue image and compares every lookup, the rename pair and the count on every cycle, so any such error is caught at its first visible cycle.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
   // index width for a range of n values, never below one bit
   function automatic int w_of(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rnm_map.sv
module rnm_map #(
   parameter int ENTRIES = 16,
   parameter int AW      = 4,
   parameter int PW      = 6,
   parameter int NRD     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NRD*AW-1:0] rd_idx,
   output logic [NRD*PW-1:0] rd_tag,
   input  logic              wa_en,
   input  logic [AW-1:0]     wa_idx,
   input  logic [PW-1:0]     wa_tag,
   input  logic              wb_en,
   input  logic [AW-1:0]     wb_idx,
   input  logic [PW-1:0]     wb_tag
);
   logic [PW-1:0] ent [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[g] <= PW'(g);
         else if (wb_en && wb_idx == AW'(g))
            ent[g] <= wb_tag;
         else if (wa_en && wa_idx == AW'(g))
            ent[g] <= wa_tag;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_tag[r*PW +: PW] = ent[rd_idx[r*AW +: AW]];
   end
endmodule

// File: rtl/rnm_free_fifo.sv
module rnm_free_fifo import rnm_pkg::*; #(
   parameter int DEPTH = 32,
   parameter int BASE  = 16,
   parameter int PW    = 6,
   parameter int CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pop,
   input  logic          push,
   input  logic [PW-1:0] push_tag,
   output logic [PW-1:0] head_tag,
   output logic [CW-1:0] count
);
   localparam int QW = w_of(DEPTH);

   logic [PW-1:0] slot [DEPTH];
   logic [QW-1:0] rd_ptr, wr_ptr;
   logic          push_ok;

   function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
      return (p == QW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign push_ok  = push && ((count != CW'(DEPTH)) || pop);
   assign head_tag = slot[rd_ptr];

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot[k] <= PW'(BASE + k);
         else if (push_ok && wr_ptr == QW'(k))
            slot[k] <= push_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= CW'(DEPTH);
      end else begin
         if (pop)     rd_ptr <= bump(rd_ptr);
         if (push_ok) wr_ptr <= bump(wr_ptr);
         count <= count + CW'(push_ok) - CW'(pop);
      end
   end
endmodule

// File: rtl/rename_table.sv
module rename_table import rnm_pkg::*; #(
   parameter int ARCH_REGS = 16,
   parameter int PHYS_REGS = 48,
   parameter int ZERO_IDX  = 0,
   parameter int NUM_SRC   = 2,
   localparam int AW    = w_of(ARCH_REGS),
   localparam int PW    = w_of(PHYS_REGS),
   localparam int DEPTH = PHYS_REGS - ARCH_REGS,
   localparam int CW    = w_of(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ren_valid,
   input  logic [AW-1:0]         ren_arch,
   output logic [PW-1:0]         ren_new,
   output logic [PW-1:0]         ren_prev,
   output logic                  ren_stall,
   input  logic [NUM_SRC*AW-1:0] lk_arch,
   output logic [NUM_SRC*PW-1:0] lk_tag,
   input  logic                  fix_valid,
   input  logic [AW-1:0]         fix_arch,
   input  logic [PW-1:0]         fix_tag,
   input  logic                  rel_valid,
   input  logic [PW-1:0]         rel_tag,
   output logic [CW-1:0]         free_cnt
);
   localparam int NRD = NUM_SRC + 1;

   if (ARCH_REGS < 1) begin : g_bad_arch
      $error("rename_table: ARCH_REGS must be at least 1");
   end
   if (PHYS_REGS <= ARCH_REGS) begin : g_bad_phys
      $error("rename_table: PHYS_REGS must exceed ARCH_REGS");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("rename_table: NUM_SRC must be at least 1");
   end

   logic              zero_hit, empty, take;
   logic [PW-1:0]     head_tag;
   logic [NRD*AW-1:0] rd_idx;
   logic [NRD*PW-1:0] rd_tag;

   if (ZERO_IDX < ARCH_REGS) begin : g_zero
      assign zero_hit = ren_valid && (ren_arch == AW'(ZERO_IDX));
   end else begin : g_nozero
      assign zero_hit = 1'b0;
   end

   assign empty     = (free_cnt == '0);
   assign take      = ren_valid && !zero_hit && !empty;
   assign ren_stall = ren_valid && !zero_hit && empty;

   assign rd_idx   = {lk_arch, ren_arch};
   assign ren_prev = rd_tag[PW-1:0];
   assign ren_new  = zero_hit ? rd_tag[PW-1:0] : head_tag;
   assign lk_tag   = rd_tag[NRD*PW-1:PW];

   rnm_map #(
      .ENTRIES(ARCH_REGS), .AW(AW), .PW(PW), .NRD(NRD)
   ) u_map (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_tag(rd_tag),
      .wa_en(take), .wa_idx(ren_arch), .wa_tag(head_tag),
      .wb_en(fix_valid), .wb_idx(fix_arch), .wb_tag(fix_tag)
   );

   rnm_free_fifo #(
      .DEPTH(DEPTH), .BASE(ARCH_REGS), .PW(PW), .CW(CW)
   ) u_free (
      .clk(clk), .rst_n(rst_n),
      .pop(take), .push(rel_valid), .push_tag(rel_tag),
      .head_tag(head_tag), .count(free_cnt)
   );
endmodule

// File: rtl/rnm_checker.sv
module rnm_checker #(
   parameter int ARCH_REGS = 16,
   parameter int PHYS_REGS = 48,
   parameter int ZERO_IDX  = 0,
   parameter int AW        = 4,
   parameter int PW        = 6,
   parameter int CW        = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ren_valid,
   input logic [AW-1:0] ren_arch,
   input logic [PW-1:0] ren_new,
   input logic [PW-1:0] ren_prev,
   input logic          ren_stall,
   input logic [AW-1:0] lk0_arch,
   input logic [PW-1:0] lk0_tag,
   input logic          fix_valid,
   input logic          rel_valid,
   input logic [CW-1:0] free_cnt
);
   localparam int  DEPTH    = PHYS_REGS - ARCH_REGS;
   localparam bit  HAS_ZERO = ZERO_IDX < ARCH_REGS;

   logic is_zero, acc;
   assign is_zero = HAS_ZERO && (int'(ren_arch) == ZERO_IDX);
   assign acc     = ren_valid && !ren_stall && !is_zero;

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(free_cnt) <= DEPTH);

   assert_cnt_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !rel_valid) |=> (free_cnt == $past(free_cnt) - 1'b1));

   assert_cnt_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc && rel_valid && int'(free_cnt) < DEPTH) |=> (free_cnt == $past(free_cnt) + 1'b1));

   assert_stall_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ren_stall |-> (ren_valid && free_cnt == '0));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_stall && !rel_valid) |=> $stable(free_cnt));

   assert_zero_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid && is_zero) |-> (ren_new == ren_prev && !ren_stall));

   assert_map_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ((lk0_arch != $past(ren_arch)) || $past(fix_valid) || (lk0_tag == $past(ren_new))));
endmodule

bind rename_table rnm_checker #(
   .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .ZERO_IDX(ZERO_IDX),
   .AW(AW), .PW(PW), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ren_valid(ren_valid), .ren_arch(ren_arch),
   .ren_new(ren_new), .ren_prev(ren_prev), .ren_stall(ren_stall),
   .lk0_arch(lk_arch[AW-1:0]), .lk0_tag(lk_tag[PW-1:0]),
   .fix_valid(fix_valid), .rel_valid(rel_valid), .free_cnt(free_cnt)
);

// File: tb/sim_rename_table.sv
module sim_rename_table;
   localparam int NA = 16, NP = 48, DEP = NP - NA;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // u0: default build, zero register at index 0
   logic        rv = 0, fv = 0, lv = 0, rstall;
   logic [3:0]  ra = 0, fa = 0;
   logic [5:0]  ft = 0, lt = 0, rnew, rprev, fc;
   logic [7:0]  lka = 0;
   logic [11:0] lkt;

   rename_table u0 (
      .clk(clk), .rst_n(rst_n), .ren_valid(rv), .ren_arch(ra),
      .ren_new(rnew), .ren_prev(rprev), .ren_stall(rstall),
      .lk_arch(lka), .lk_tag(lkt),
      .fix_valid(fv), .fix_arch(fa), .fix_tag(ft),
      .rel_valid(lv), .rel_tag(lt), .free_cnt(fc)
   );

   // u1: small build without a zero register
   logic       rv1 = 0, rstall1;
   logic [1:0] ra1 = 0, lka1 = 0, fc1;
   logic [2:0] rnew1, rprev1, lkt1;

   rename_table #(.ARCH_REGS(4), .PHYS_REGS(6), .ZERO_IDX(4), .NUM_SRC(1)) u1 (
      .clk(clk), .rst_n(rst_n), .ren_valid(rv1), .ren_arch(ra1),
      .ren_new(rnew1), .ren_prev(rprev1), .ren_stall(rstall1),
      .lk_arch(lka1), .lk_tag(lkt1),
      .fix_valid(1'b0), .fix_arch(2'd0), .fix_tag(3'd0),
      .rel_valid(1'b0), .rel_tag(3'd0), .free_cnt(fc1)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference image
   int m_map [NA];
   int m_q   [DEP];
   int m_hd = 0, m_tl = 0, m_cnt = DEP;
   int pend [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < NA; i++) m_map[i] = i;
      for (int k = 0; k < DEP; k++) m_q[k] = NA + k;
      m_hd = 0; m_tl = 0; m_cnt = DEP;
      pend.delete();
   endfunction

   // one cycle: drive at falling edge, compare before the rising edge, then update model
   task automatic step(input bit r, input int a, input bit f, input int fai, input int fti,
                       input bit l, input int lti, input int s0, input int s1);
      bit zero, exp_stall, acc;
      int exp_new, exp_prev;
      @(negedge clk);
      rv = r; ra = 4'(a); fv = f; fa = 4'(fai); ft = 6'(fti);
      lv = l; lt = 6'(lti); lka = {4'(s1), 4'(s0)};
      #2;
      zero      = r && (a == 0);
      exp_stall = r && !zero && (m_cnt == 0);
      acc       = r && !zero && (m_cnt != 0);
      exp_prev  = m_map[a];
      exp_new   = zero ? m_map[a] : m_q[m_hd];
      chk(int'(rstall) == int'(exp_stall), "R8 stall", int'(rstall), int'(exp_stall));
      if (r) chk(int'(rprev) == exp_prev, "R2 prev tag", int'(rprev), exp_prev);
      if (acc || zero) chk(int'(rnew) == exp_new, zero ? "R3 zero new tag" : "R2 new tag",
                           int'(rnew), exp_new);
      chk(int'(lkt[5:0]) == m_map[s0], "R5 lookup0", int'(lkt[5:0]), m_map[s0]);
      chk(int'(lkt[11:6]) == m_map[s1], "R5 lookup1", int'(lkt[11:6]), m_map[s1]);
      chk(int'(fc) == m_cnt, "R7 free count", int'(fc), m_cnt);
      @(posedge clk);
      if (l && (m_cnt < DEP || acc)) begin
         m_q[m_tl] = lti; m_tl = (m_tl + 1) % DEP; m_cnt++;
      end
      if (acc) begin
         m_map[a] = exp_new; m_hd = (m_hd + 1) % DEP; m_cnt--;
         pend.push_back(exp_prev);
      end
      if (f) m_map[fai] = fti;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int rel;
      void'($urandom(32'h1DEA));
      model_reset();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1 reset mapping and count
      for (int i = 0; i < NA; i += 2) step(0, 0, 0, 0, 0, 0, 0, i, i + 1);
      chk(int'(fc) == DEP, "R1 reset count", int'(fc), DEP);

      // R1/R2 first rename gets tag 16, prev 5
      step(1, 5, 0, 0, 0, 0, 0, 5, 1);
      chk(int'(rnew) == NA, "R1 first tag", int'(rnew), NA);
      // R5 same-cycle lookup returns old tag 16 while rename moves 5 to 17
      step(1, 5, 0, 0, 0, 0, 0, 5, 5);
      chk(int'(lkt[5:0]) == NA, "R5 pre-rename lookup", int'(lkt[5:0]), NA);
      idle();
      chk(int'(lkt[5:0]) == 0, "R5 sanity idx0", int'(lkt[5:0]), 0);
      step(0, 0, 0, 0, 0, 0, 0, 5, 0);
      chk(int'(lkt[5:0]) == NA + 1, "R2 map updated", int'(lkt[5:0]), NA + 1);

      // R3 zero register rename: no pop, map unchanged
      step(1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk(rnew == rprev && rprev == 0, "R3 zero pair", int'(rnew), 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk(int'(fc) == DEP - 2, "R3 no pop", int'(fc), DEP - 2);

      // R6 set-entry wins over same-index rename, and writes zero register too
      step(1, 7, 1, 7, 40, 0, 0, 7, 0);
      step(0, 0, 1, 0, 33, 0, 0, 7, 0);
      chk(int'(lkt[5:0]) == 40, "R6 fix wins", int'(lkt[5:0]), 40);
      idle();
      chk(int'(lkt[5:0]) == 33, "R6 zero entry forced", int'(lkt[5:0]), 33);
      step(0, 0, 1, 0, 0, 0, 0, 0, 0);

      // R7 release and rename together keep the count
      rel = pend.pop_front();
      step(1, 3, 0, 0, 0, 1, rel, 3, 4);
      chk(int'(fc) == DEP - 3, "R7 count before", int'(fc), DEP - 3);
      idle();
      chk(int'(fc) == DEP - 3, "R7 push+pop", int'(fc), DEP - 3);

      // R8 drain to empty, then stall with map untouched
      while (m_cnt > 0) step(1, 1 + ($urandom % 15), 0, 0, 0, 0, 0, 2, 9);
      step(1, 9, 0, 0, 0, 0, 0, 9, 2);
      chk(rstall == 1'b1, "R8 stall when empty", int'(rstall), 1);
      step(0, 0, 0, 0, 0, 0, 0, 9, 2);
      chk(int'(fc) == 0, "R8 count held", int'(fc), 0);
      // R3 zero rename allowed while empty
      step(1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk(rstall == 1'b0, "R3 zero no stall", int'(rstall), 0);
      // R7 released tag is the next one handed out
      rel = pend.pop_front();
      step(0, 0, 0, 0, 0, 1, rel, 0, 0);
      step(1, 6, 0, 0, 0, 0, 0, 6, 0);
      chk(int'(rnew) == rel, "R7 release order", int'(rnew), rel);

      // mixed random traffic
      for (int c = 0; c < 4000; c++) begin
         bit r, f, l;
         int rl;
         r  = ($urandom % 4) != 0;
         f  = ($urandom % 16) == 0;
         l  = (pend.size() > 0) && (($urandom % 3) != 0);
         rl = l ? pend.pop_front() : 0;
         step(r, $urandom % NA, f, $urandom % NA, $urandom % NP, l, rl,
              $urandom % NA, $urandom % NA);
      end

      // R4 no zero register: index 0 renames normally in u1
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1; rv1 = 1; ra1 = 0; lka1 = 0;
      #2;
      chk(rnew1 == 3'd4 && rprev1 == 3'd0 && !rstall1, "R4 no zero reg", int'(rnew1), 4);
      @(negedge clk);
      rv1 = 0;
      #2;
      chk(int'(lkt1) == 4, "R4 index0 remapped", int'(lkt1), 4);
      chk(int'(fc1) == 1, "R4 count", int'(fc1), 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule